// File: doc/BRIEF.md
# Floating-point exception flag accumulator

This block sits beside a floating-point unit and holds the sticky exception flags of the floating-point control/status register. Each completed operation presents a one-cycle valid strobe together with a vector of status classes. The block turns those classes into register flags: several kinds of invalid operation fold into one combined invalid flag, and separate sub-flags mark signalling NaN, quiet NaN and infinity cases. Flags are only ever ORed in. Software clears them by writing the register through the write port.

The flags change only while the register's enable bit is set. After each enabled operation the block looks at the whole updated register, not only at the new status. If any of the eight flags is 1, it raises an exception request for one cycle and reports the previous-PC value that came with the operation as the faulting address. A register write and an operation in the same cycle are merged. The written value applies first, including its enable bit, and the operation's flags are then ORed on top.

Top module: `fpflag_accum`

## Requirements
- R1: While rst_n is low and after its release, csr_q_o, fpe_req_o and fpe_addr_o are all zero.
- R2: A write (csr_we_i high) loads csr_wdata_i into the register, visible on csr_q_o the next cycle. Bit 0 is the enable, bits 3..1 are the rounding mode and are stored as written, and bit 8 is reserved and always reads 0.
- R3: An enabled operation with any of status bits 0..8 set (0 signalling NaN, 1 quiet NaN, 2 inf-inf, 3 inf/inf, 4 0/0, 5 inf*0, 6 bad conversion, 7 bad compare, 8 bad sqrt) sets the invalid flag, register bit 10.
- R4: Status bit 0 also sets the signalling-NaN flag at bit 6. Status bit 1 also sets the quiet-NaN flag at bit 7.
- R5: The infinity flag at bit 11 is set by status bit 2 or 3, and by no other status bit.
- R6: Status bit 9 (overflow) sets bit 4, bit 10 (underflow) sets bit 5, bit 11 (divide by zero) sets bit 12, and bit 12 (inexact) sets bit 9.
- R7: Flags are sticky. An operation never clears a flag, and only a register write can clear one.
- R8: While the effective enable bit is 0, an operation changes no register bit and raises no request.
- R9: One cycle after an enabled operation, fpe_req_o is high for one cycle if any flag bit (4,5,6,7,9,10,11,12) of the updated register is 1. This holds even when the new status is all zero. fpe_addr_o then shows the prev_pc_i value presented with that operation.
- R10: A write and an operation in the same cycle take the written value first, including its enable bit, and then OR in the operation's flags.
- R11: Without a valid operation, fpe_req_o stays low and fpe_addr_o holds its value, whatever flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | An operation completes this cycle |
| op_status_i | input | 13 | Status classes of the operation |
| prev_pc_i | input | ADDR_W | Previous-PC value for the operation |
| csr_we_i | input | 1 | Register write strobe |
| csr_wdata_i | input | 13 | Register write data |
| csr_q_o | output | 13 | Current register value |
| fpe_req_o | output | 1 | Floating-point exception request |
| fpe_addr_o | output | ADDR_W | Faulting address for the request |

## Verification
The assertions assume op_status_i and prev_pc_i are meaningful only while op_valid_i is high. They also assume every input settles once per cycle, away from the clock edge. The stimulus changes all inputs on the falling edge and presents a status vector only together with a valid strobe. The register is cleared or disabled through writes between directed cases, so each case starts from a known value. The random phase then mixes writes, operations and idle cycles freely.

// File: rtl/fpflag_pkg.sv
package fpflag_pkg;
  parameter int CSR_W = 13;
  parameter int ST_W  = 13;

  localparam int B_EN  = 0;
  localparam int B_OVF = 4;
  localparam int B_UNF = 5;
  localparam int B_SNF = 6;
  localparam int B_QNF = 7;
  localparam int B_RSV = 8;
  localparam int B_IXF = 9;
  localparam int B_IVF = 10;
  localparam int B_INF = 11;
  localparam int B_DZF = 12;

  localparam int S_SNAN = 0;
  localparam int S_QNAN = 1;
  localparam int S_ISI  = 2;
  localparam int S_IDI  = 3;
  localparam int S_INV_LAST = 8;
  localparam int S_OVF  = 9;
  localparam int S_UNF  = 10;
  localparam int S_DIV0 = 11;
  localparam int S_INEX = 12;

  localparam logic [CSR_W-1:0] FLAG_MASK =
    (CSR_W'(1) << B_OVF) | (CSR_W'(1) << B_UNF) | (CSR_W'(1) << B_SNF) |
    (CSR_W'(1) << B_QNF) | (CSR_W'(1) << B_IXF) | (CSR_W'(1) << B_IVF) |
    (CSR_W'(1) << B_INF) | (CSR_W'(1) << B_DZF);
  localparam logic [CSR_W-1:0] WR_MASK = ~(CSR_W'(1) << B_RSV);
endpackage

// File: rtl/fpflag_map.sv
module fpflag_map
  import fpflag_pkg::*;
(
  input  logic [ST_W-1:0]  status_i,
  output logic [CSR_W-1:0] flags_o
);
  always_comb begin
    flags_o        = '0;
    flags_o[B_IVF] = |status_i[S_INV_LAST:0];
    flags_o[B_SNF] = status_i[S_SNAN];
    flags_o[B_QNF] = status_i[S_QNAN];
    flags_o[B_INF] = status_i[S_ISI] | status_i[S_IDI];
    flags_o[B_OVF] = status_i[S_OVF];
    flags_o[B_UNF] = status_i[S_UNF];
    flags_o[B_DZF] = status_i[S_DIV0];
    flags_o[B_IXF] = status_i[S_INEX];
  end
endmodule

// File: rtl/fpflag_csr.sv
module fpflag_csr
  import fpflag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid_i,
  input  logic [CSR_W-1:0] op_flags_i,
  input  logic             we_i,
  input  logic [CSR_W-1:0] wdata_i,
  output logic [CSR_W-1:0] csr_d_o,
  output logic             en_eff_o,
  output logic [CSR_W-1:0] csr_q_o
);
  logic [CSR_W-1:0] base;
  logic [CSR_W-1:0] csr_q;

  always_comb begin
    base     = we_i ? (wdata_i & WR_MASK) : csr_q;
    en_eff_o = base[B_EN];
    csr_d_o  = base;
    if (op_valid_i && en_eff_o)
      csr_d_o = base | (op_flags_i & FLAG_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csr_q <= '0;
    else        csr_q <= csr_d_o;
  end

  assign csr_q_o = csr_q;

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we_i) |-> ((csr_q & $past(csr_q) & FLAG_MASK) == ($past(csr_q) & FLAG_MASK)));
  p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && !csr_q[B_EN]) |=> (csr_q == $past(csr_q)));
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[B_RSV] == 1'b0);
endmodule

// File: rtl/fpflag_req.sv
module fpflag_req
  import fpflag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid_i,
  input  logic              en_eff_i,
  input  logic [CSR_W-1:0]  csr_d_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              req_d;
  logic              req_q;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    req_d = op_valid_i && en_eff_i && ((csr_d_i & FLAG_MASK) != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q <= req_d;
      if (req_d) addr_q <= pc_i;
    end
  end

  assign req_o  = req_q;
  assign addr_o = addr_q;

  p_req_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (addr_q == $past(pc_i)));
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_valid_i) |-> (!req_q && $stable(addr_q)));
endmodule

// File: rtl/fpflag_accum.sv
module fpflag_accum
  import fpflag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid_i,
  input  logic [ST_W-1:0]   op_status_i,
  input  logic [ADDR_W-1:0] prev_pc_i,
  input  logic              csr_we_i,
  input  logic [CSR_W-1:0]  csr_wdata_i,
  output logic [CSR_W-1:0]  csr_q_o,
  output logic              fpe_req_o,
  output logic [ADDR_W-1:0] fpe_addr_o
);
  logic [CSR_W-1:0] op_flags;
  logic [CSR_W-1:0] csr_d;
  logic             en_eff;

  fpflag_map u_map (
    .status_i (op_status_i),
    .flags_o  (op_flags)
  );

  fpflag_csr u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid_i (op_valid_i),
    .op_flags_i (op_flags),
    .we_i       (csr_we_i),
    .wdata_i    (csr_wdata_i),
    .csr_d_o    (csr_d),
    .en_eff_o   (en_eff),
    .csr_q_o    (csr_q_o)
  );

  fpflag_req #(.ADDR_W(ADDR_W)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid_i (op_valid_i),
    .en_eff_i   (en_eff),
    .csr_d_i    (csr_d),
    .pc_i       (prev_pc_i),
    .req_o      (fpe_req_o),
    .addr_o     (fpe_addr_o)
  );

  p_req_has_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fpe_req_o |-> ((csr_q_o & FLAG_MASK) != '0));
  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fpe_req_o |-> $past(op_valid_i));
  p_req_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fpe_req_o |-> csr_q_o[B_EN]);
endmodule

// File: tb/fpflag_accum_tb.sv
`timescale 1ns/1ps
module fpflag_accum_tb_top;
  localparam int AW = 32;
  localparam logic [12:0] FM = 13'h1EF0;

  typedef struct {
    string       tag;
    logic [12:0] q;
    logic        req;
    logic [AW-1:0] addr;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_valid_i;
  logic [12:0]   op_status_i;
  logic [AW-1:0] prev_pc_i;
  logic          csr_we_i;
  logic [12:0]   csr_wdata_i;
  logic [12:0]   csr_q_o;
  logic          fpe_req_o;
  logic [AW-1:0] fpe_addr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t sb[$];

  logic [12:0]   m_q;
  logic [AW-1:0] m_addr;

  always #4 clk = ~clk;

  fpflag_accum #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_status_i(op_status_i),
    .prev_pc_i(prev_pc_i), .csr_we_i(csr_we_i), .csr_wdata_i(csr_wdata_i),
    .csr_q_o(csr_q_o), .fpe_req_o(fpe_req_o), .fpe_addr_o(fpe_addr_o)
  );

  function automatic logic [12:0] to_flags(logic [12:0] s);
    logic [12:0] f = '0;
    if (s[8:0] != 0)    f[10] = 1'b1;
    if (s[0])           f[6]  = 1'b1;
    if (s[1])           f[7]  = 1'b1;
    if (s[2] || s[3])   f[11] = 1'b1;
    if (s[9])           f[4]  = 1'b1;
    if (s[10])          f[5]  = 1'b1;
    if (s[11])          f[12] = 1'b1;
    if (s[12])          f[9]  = 1'b1;
    return f;
  endfunction

  task automatic check(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic v, logic [12:0] st, logic [AW-1:0] pc,
                      logic we, logic [12:0] wd);
    exp_t e;
    logic [12:0] b;
    logic r;
    @(negedge clk);
    op_valid_i = v; op_status_i = st; prev_pc_i = pc;
    csr_we_i = we; csr_wdata_i = wd;
    b = we ? (wd & 13'h1EFF) : m_q;
    r = 1'b0;
    if (v && b[0]) begin
      b = b | to_flags(st);
      r = (b & FM) != 0;
    end
    if (r) m_addr = pc;
    m_q = b;
    e.tag = tag; e.q = m_q; e.req = r; e.addr = m_addr;
    sb.push_back(e);
    @(posedge clk);
  endtask

  always @(posedge clk) begin
    if (sb.size() != 0) begin
      exp_t e;
      #2;
      e = sb.pop_front();
      check(e.tag, "csr_q", AW'(csr_q_o), AW'(e.q));
      check(e.tag, "req", AW'(fpe_req_o), AW'(e.req));
      check(e.tag, "addr", fpe_addr_o, e.addr);
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid_i = 0; op_status_i = 0; prev_pc_i = 0;
    csr_we_i = 0; csr_wdata_i = 0;
    m_q = 0; m_addr = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", "csr_q in reset", AW'(csr_q_o), 0);
    check("R1", "req in reset", AW'(fpe_req_o), 0);
    check("R1", "addr in reset", fpe_addr_o, 0);
    @(negedge clk); rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0);
    // R2: write with reserved bit dropped, rounding bits kept
    step("R2", 0, 0, 0, 1, 13'h1FFF);
    step("R2", 0, 0, 0, 1, 13'h000B);
    // R3..R6: each status class alone, cleared in between
    for (int i = 0; i < 13; i++) begin
      step("R3_R6_clear", 0, 0, 0, 1, 13'h0001);
      step(i <= 8 ? (i < 2 ? "R4" : (i < 4 ? "R5" : "R3")) : "R6",
           1, 13'(1) << i, 32'h1000 + i, 0, 0);
    end
    // R7: sticky accumulation
    step("R7", 0, 0, 0, 1, 13'h0001);
    step("R7", 1, 13'h0200, 32'h2000, 0, 0);
    step("R7", 1, 13'h1000, 32'h2004, 0, 0);
    // R9: zero status still requests on accumulated flags
    step("R9", 1, 13'h0000, 32'h2008, 0, 0);
    // R11: idle cycles, no request, address held
    step("R11", 0, 0, 32'hDEAD, 0, 0);
    step("R11", 0, 13'h1FFF, 32'hBEEF, 0, 0);
    // R8: disabled, flags untouched and no request
    step("R8", 0, 0, 0, 1, 13'h0030);
    step("R8", 1, 13'h1FFF, 32'h3000, 0, 0);
    // R10: write and op merged
    step("R10", 1, 13'h0200, 32'h4000, 1, 13'h0001);
    step("R10", 1, 13'h1FFF, 32'h4004, 1, 13'h0000);
    step("R10", 1, 13'h0000, 32'h4008, 1, 13'h0011);
    // R9: enabled op with no flags anywhere gives no request
    step("R9", 0, 0, 0, 1, 13'h0001);
    step("R9", 1, 13'h0000, 32'h5000, 0, 0);
    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      logic v, w;
      logic [12:0] st, wd;
      v  = ($urandom % 3) != 0;
      w  = ($urandom % 6) == 0;
      st = v ? 13'($urandom & (($urandom % 2) ? 32'h1FFF : 32'h0001 << ($urandom % 13))) : 13'h0;
      wd = 13'($urandom) | (($urandom % 4) != 0 ? 13'h1 : 13'h0);
      step("R9", v, st, $urandom, w, wd);
    end
    step("R7", 0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule